// File: doc/BRIEF.md
# Fail-Safe Clock Failure Monitor

This block watches the active system clock against an always-running low-power reference oscillator. The reference clock divides time into fixed windows. A small logic stage in the monitored clock domain counts its own edges. At each window boundary the reference side asks for that count through a toggle handshake. If a request gets no answer within the next window, or the answer reports no edges, the monitored clock is declared dead.

On a failure the block gives a one-cycle trap pulse and sets a sticky failure flag. While that flag is high it drives a forced clock-select code that moves the system clock to the fast internal RC oscillator. If the PLL was in use, the code selects the fast RC through the PLL, so the multiplier stays the same. A later software-started clock switch clears the flag. The block also asks for the reference oscillator to be kept running whenever monitoring is enabled and the device is awake, whatever the watchdog setting. Monitoring pauses during sleep and while a clock switch waits for oscillator start-up or PLL lock.

All outputs are registered or plain combinational status in the reference clock domain. There is no streaming data path, so no port uses a valid/ready handshake and there is no back-pressure. The monitored clock is assumed to run several times faster than the reference clock.

Top module: `fscm_monitor`

## Requirements
- R1: `lprc_keep_o` is high exactly when `cfg_en` is high and `sleep_i` is low.
- R2: With `cfg_en` low, no failure is ever flagged, whether or not the monitored clock runs.
- R3: Edges are checked over windows of WIN=4 reference periods. Once the monitored clock stops while monitoring is active, `fail_o` goes high within 16 reference cycles of active, dead time.
- R4: While the monitored clock runs at least five times faster than the reference, no failure is flagged. After it restarts, no new failure appears once it has run for 16 reference cycles.
- R5: `trap_o` is high for exactly one reference cycle: the cycle in which `fail_o` first reads high.
- R6: `fail_o` stays high until `sw_start` is sampled high. It then reads low in the following cycle, provided no new failure is detected in that cycle.
- R7: In the cycle `fail_o` rises, `force_sel_o` holds 3'd0 (fast RC) if `pll_on` was low at detection, or 3'd1 (fast RC through PLL) if it was high. The code stays stable while `fail_o` is high.
- R8: While `sleep_i` or `sw_wait` is high, no failure is detected. When both drop, monitoring resumes and a dead clock is again caught within the R3 bound.
- R9: During reset `trap_o`, `fail_o` and `force_sel_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Low-power reference clock; all outputs are in this domain |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| clk_mon | input | 1 | System clock being watched |
| cfg_en | input | 1 | Configuration enable for monitoring and clock switching |
| sleep_i | input | 1 | Device is in sleep |
| sw_wait | input | 1 | A clock switch is waiting for start-up or PLL lock |
| sw_start | input | 1 | One-cycle pulse: a valid software clock switch begins |
| pll_on | input | 1 | The PLL currently scales the system clock |
| trap_o | output | 1 | One-cycle clock-failure trap pulse |
| fail_o | output | 1 | Sticky clock-failure flag; also enables the forced select |
| force_sel_o | output | 3 | Fallback source code, 0 = fast RC, 1 = fast RC with PLL |
| lprc_keep_o | output | 1 | Keeps the reference oscillator powered |

## Verification
A window counter or armed flag that is wrong, or a stale handshake toggle, shows at the ports as a trap with no failure behind it, or as a dead clock that goes unreported. The bench compares the outputs every reference cycle against a model built from the time the monitored clock has been stopped or running. A false failure is therefore caught in the cycle it appears, and a missed one within 16 cycles. A wrong latch of the fallback code or a lost sticky bit shows in the cycle `fail_o` rises, or in the cycle after it should have held.

// File: rtl/fscm_pkg.sv
package fscm_pkg;
  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] SRC_FAST_RC     = 3'd0;
  localparam logic [SEL_W-1:0] SRC_FAST_RC_PLL = 3'd1;

  function automatic logic [SEL_W-1:0] fallback_code(input logic pll_used);
    return pll_used ? SRC_FAST_RC_PLL : SRC_FAST_RC;
  endfunction
endpackage

// File: rtl/fscm_sync.sv
module fscm_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st <= '0;
        else        st <= d;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st <= '0;
        else        st <= {st[STAGES-2:0], d};
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/fscm_mon_side.sv
// Runs on the monitored clock: counts its edges and answers each
// request toggle with a held count and an echo toggle.
module fscm_mon_side #(
  parameter int CNT_W  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk_mon,
  input  logic             rst_n,
  input  logic             req_i,
  output logic             ack_o,
  output logic [CNT_W-1:0] hold_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [1:0]       rst_sh;
  logic             mrst_n;
  logic             req_s;
  logic             req_d;
  logic [CNT_W-1:0] edge_cnt;
  logic [CNT_W-1:0] edge_inc;

  always_ff @(posedge clk_mon or negedge rst_n)
    if (!rst_n) rst_sh <= 2'b00;
    else        rst_sh <= {rst_sh[0], 1'b1};
  assign mrst_n = rst_sh[1];

  fscm_sync #(.W(1), .STAGES(STAGES)) u_req_sync (
    .clk(clk_mon), .rst_n(mrst_n), .d(req_i), .q(req_s)
  );

  assign edge_inc = (edge_cnt == CNT_MAX) ? CNT_MAX : edge_cnt + 1'b1;

  always_ff @(posedge clk_mon or negedge mrst_n) begin
    if (!mrst_n) begin
      req_d    <= 1'b0;
      edge_cnt <= '0;
      hold_o   <= '0;
      ack_o    <= 1'b0;
    end else begin
      req_d <= req_s;
      if (req_s != req_d) begin
        hold_o   <= edge_inc;
        edge_cnt <= '0;
        ack_o    <= ~ack_o;
      end else begin
        edge_cnt <= edge_inc;
      end
    end
  end
endmodule

// File: rtl/fscm_window.sv
// Reference-domain window engine: issues a request at each window end
// and judges the answer to the previous request.
module fscm_window #(
  parameter int WIN   = 4,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  input  logic             ack_s_i,
  input  logic [CNT_W-1:0] hold_i,
  output logic             req_o,
  output logic             fail_det_o
);
  localparam int WC_W = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [WC_W-1:0] WC_LAST = WC_W'(WIN - 1);

  logic [WC_W-1:0]  win_cnt;
  logic             armed;
  logic             ack_d;
  logic             ack_edge;
  logic [CNT_W-1:0] cap_q;
  logic [CNT_W-1:0] cap_now;
  logic             end_win;
  logic             unanswered;

  assign ack_edge   = ack_s_i ^ ack_d;
  assign cap_now    = ack_edge ? hold_i : cap_q;
  assign end_win    = active_i && (win_cnt == WC_LAST);
  assign unanswered = (ack_s_i != req_o) || (cap_now == '0);
  assign fail_det_o = end_win && armed && unanswered;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt <= '0;
      armed   <= 1'b0;
      req_o   <= 1'b0;
      ack_d   <= 1'b0;
      cap_q   <= '0;
    end else begin
      ack_d <= ack_s_i;
      if (ack_edge) cap_q <= hold_i;
      if (!active_i) begin
        win_cnt <= '0;
        armed   <= 1'b0;
      end else begin
        win_cnt <= end_win ? '0 : win_cnt + 1'b1;
        if (end_win) begin
          req_o <= ~req_o;
          armed <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fscm_monitor.sv
module fscm_monitor
  import fscm_pkg::*;
#(
  parameter int WIN    = 4,
  parameter int CNT_W  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             clk_mon,
  input  logic             cfg_en,
  input  logic             sleep_i,
  input  logic             sw_wait,
  input  logic             sw_start,
  input  logic             pll_on,
  output logic             trap_o,
  output logic             fail_o,
  output logic [SEL_W-1:0] force_sel_o,
  output logic             lprc_keep_o
);
  logic             req;
  logic             ack_m;
  logic             ack_s;
  logic [CNT_W-1:0] hold;
  logic             active;
  logic             fail_det;

  assign active      = cfg_en && !sleep_i && !sw_wait && !fail_o;
  assign lprc_keep_o = cfg_en && !sleep_i;

  fscm_mon_side #(.CNT_W(CNT_W), .STAGES(STAGES)) u_mon (
    .clk_mon(clk_mon), .rst_n(rst_n), .req_i(req),
    .ack_o(ack_m), .hold_o(hold)
  );

  fscm_sync #(.W(1), .STAGES(STAGES)) u_ack_sync (
    .clk(clk_ref), .rst_n(rst_n), .d(ack_m), .q(ack_s)
  );

  fscm_window #(.WIN(WIN), .CNT_W(CNT_W)) u_win (
    .clk(clk_ref), .rst_n(rst_n), .active_i(active),
    .ack_s_i(ack_s), .hold_i(hold),
    .req_o(req), .fail_det_o(fail_det)
  );

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      trap_o      <= 1'b0;
      fail_o      <= 1'b0;
      force_sel_o <= '0;
    end else begin
      trap_o <= fail_det;
      if (fail_det) begin
        fail_o      <= 1'b1;
        force_sel_o <= fallback_code(pll_on);
      end else if (sw_start) begin
        fail_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fscm_monitor_chk.sv
module fscm_monitor_chk (
  input logic       clk_ref,
  input logic       rst_n,
  input logic       cfg_en,
  input logic       sleep_i,
  input logic       sw_wait,
  input logic       sw_start,
  input logic       pll_on,
  input logic       trap_o,
  input logic       fail_o,
  input logic [2:0] force_sel_o
);
  // R5
  trap_single_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    trap_o |=> !trap_o);
  // R5
  trap_on_rise_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    trap_o |-> (fail_o && !$past(fail_o)));
  // R6
  fail_sticky_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (fail_o && !sw_start) |=> fail_o);
  // R6
  fail_needs_trap_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(fail_o) |-> trap_o);
  // R2
  no_trap_disabled_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    trap_o |-> $past(cfg_en));
  // R8
  no_trap_paused_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    trap_o |-> (!$past(sleep_i) && !$past(sw_wait)));
  // R7
  sel_code_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    trap_o |-> (force_sel_o == ($past(pll_on) ? 3'd1 : 3'd0)));
  // R7
  sel_hold_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (fail_o && !trap_o) |-> $stable(force_sel_o));
endmodule

bind fscm_monitor fscm_monitor_chk u_chk (
  .clk_ref(clk_ref), .rst_n(rst_n), .cfg_en(cfg_en), .sleep_i(sleep_i),
  .sw_wait(sw_wait), .sw_start(sw_start), .pll_on(pll_on),
  .trap_o(trap_o), .fail_o(fail_o), .force_sel_o(force_sel_o)
);

// File: tb/fscm_monitor_tb.sv
module fscm_monitor_tb;
  localparam int WIN   = 4;
  localparam int BOUND = 3 * WIN + 4;

  logic       clk_ref = 1'b0;
  logic       clk_mon = 1'b0;
  logic       rst_n   = 1'b0;
  logic       cfg_en  = 1'b0;
  logic       sleep_i = 1'b0;
  logic       sw_wait = 1'b0;
  logic       sw_start = 1'b0;
  logic       pll_on  = 1'b0;
  logic       mon_run = 1'b1;
  logic       trap_o, fail_o, lprc_keep_o;
  logic [2:0] force_sel_o;

  int n_chk = 0;
  int n_fail = 0;
  bit mdl_on = 0;
  bit finished = 0;

  // model state
  bit prev_fail = 0, prev_sw = 0, prev_act = 0, prev_pll = 0;
  bit prev_cfg = 0, prev_sleep = 0, prev_wait = 0;
  int dead_cnt = 0, live_cnt = 0;

  fscm_monitor #(.WIN(WIN)) u_dut (
    .clk_ref(clk_ref), .rst_n(rst_n), .clk_mon(clk_mon), .cfg_en(cfg_en),
    .sleep_i(sleep_i), .sw_wait(sw_wait), .sw_start(sw_start), .pll_on(pll_on),
    .trap_o(trap_o), .fail_o(fail_o), .force_sel_o(force_sel_o),
    .lprc_keep_o(lprc_keep_o)
  );

  always #5 clk_ref = ~clk_ref;
  always begin
    #1;
    if (mon_run) clk_mon = ~clk_mon;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model compared on every reference clock
  always @(negedge clk_ref) begin
    if (mdl_on && !finished) begin
      chk(lprc_keep_o == (cfg_en && !sleep_i), "R1", lprc_keep_o, cfg_en && !sleep_i);
      chk(trap_o == (fail_o && !prev_fail), "R5", trap_o, fail_o && !prev_fail);
      if (fail_o && !prev_fail) begin
        chk(prev_cfg, "R2", prev_cfg, 1);
        chk(!prev_sleep && !prev_wait, "R8", prev_sleep | prev_wait, 0);
        chk(live_cnt <= BOUND, "R4", live_cnt, BOUND);
        chk(force_sel_o == (prev_pll ? 3'd1 : 3'd0), "R7", force_sel_o, prev_pll);
      end
      if (prev_fail && !prev_sw)
        chk(fail_o == 1'b1, "R6", fail_o, 1);
      if (prev_sw && mon_run && live_cnt > BOUND)
        chk(fail_o == 1'b0, "R6", fail_o, 0);
      if (!mon_run && cfg_en && !sleep_i && !sw_wait && !fail_o) dead_cnt++;
      else dead_cnt = 0;
      chk(dead_cnt <= BOUND, "R3", dead_cnt, BOUND);
      if (mon_run) live_cnt++;
      else live_cnt = 0;
      prev_fail  = fail_o;
      prev_sw    = sw_start;
      prev_pll   = pll_on;
      prev_cfg   = cfg_en;
      prev_sleep = sleep_i;
      prev_wait  = sw_wait;
      prev_act   = cfg_en && !sleep_i && !sw_wait;
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_ref);
      #1;
    end
  endtask

  task automatic clear_fail();
    sw_start = 1'b1;
    cyc(1);
    sw_start = 1'b0;
    cyc(1);
  endtask

  task automatic fin();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk_ref);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    fin();
  end

  initial begin
    // R9: reset state
    cyc(3);
    @(negedge clk_ref);
    chk(trap_o == 0 && fail_o == 0 && force_sel_o == 0, "R9",
        {trap_o, fail_o, force_sel_o}, 0);
    @(posedge clk_ref); #1;
    rst_n = 1'b1;
    cyc(2);
    mdl_on = 1;

    // R2: disabled, clock dead, no failure, keep-alive low (R1)
    mon_run = 1'b0;
    cyc(40);
    chk(fail_o == 0, "R2", fail_o, 0);
    chk(lprc_keep_o == 0, "R1", lprc_keep_o, 0);
    mon_run = 1'b1;
    cyc(BOUND + 2);

    // R4: enabled, healthy clock
    cfg_en = 1'b1;
    cyc(80);
    chk(fail_o == 0, "R4", fail_o, 0);
    chk(lprc_keep_o == 1, "R1", lprc_keep_o, 1);

    // R3/R7: stop clock without PLL
    pll_on = 1'b0;
    mon_run = 1'b0;
    cyc(BOUND + 2);
    chk(fail_o == 1, "R3", fail_o, 1);
    chk(force_sel_o == 3'd0, "R7", force_sel_o, 0);
    cyc(10);
    chk(fail_o == 1, "R6", fail_o, 1);
    mon_run = 1'b1;
    cyc(BOUND + 2);
    clear_fail();
    chk(fail_o == 0, "R6", fail_o, 0);
    cyc(40);
    chk(fail_o == 0, "R4", fail_o, 0);

    // R7: with PLL in use
    pll_on = 1'b1;
    cyc(10);
    mon_run = 1'b0;
    cyc(BOUND + 2);
    chk(fail_o == 1, "R3", fail_o, 1);
    chk(force_sel_o == 3'd1, "R7", force_sel_o, 1);
    mon_run = 1'b1;
    cyc(BOUND + 2);
    clear_fail();
    chk(fail_o == 0, "R6", fail_o, 0);
    pll_on = 1'b0;
    cyc(20);

    // R8: sleep pauses monitoring and drops keep-alive
    sleep_i = 1'b1;
    cyc(2);
    mon_run = 1'b0;
    cyc(50);
    chk(fail_o == 0, "R8", fail_o, 0);
    chk(lprc_keep_o == 0, "R1", lprc_keep_o, 0);
    sleep_i = 1'b0;
    cyc(BOUND + 2);
    chk(fail_o == 1, "R8", fail_o, 1);
    mon_run = 1'b1;
    cyc(BOUND + 2);
    clear_fail();
    cyc(20);

    // R8: switch wait pauses monitoring
    sw_wait = 1'b1;
    cyc(2);
    mon_run = 1'b0;
    cyc(50);
    chk(fail_o == 0, "R8", fail_o, 0);
    chk(lprc_keep_o == 1, "R1", lprc_keep_o, 1);
    sw_wait = 1'b0;
    cyc(BOUND + 2);
    chk(fail_o == 1, "R8", fail_o, 1);
    mon_run = 1'b1;
    cyc(BOUND + 2);
    clear_fail();
    cyc(60);
    chk(fail_o == 0, "R4", fail_o, 0);

    fin();
  end
endmodule